// File: doc/BRIEF.md
# SPI Interrupt Status and Mask Unit

This block holds the interrupt registers of a SPI controller. The transmit FIFO, the receive FIFO and the serial engine stay outside it; their fill counts, full flag and bus fault line come in as inputs. Every clock cycle the unit turns those inputs into sticky event bits, gates them with a software mask, and raises a single level interrupt while any enabled event is pending.

Software reaches the unit through a simple register port. It can read pending events and clear them by writing ones. It can turn on mask bits through one write-only register and turn them off through another, then read the resulting mask back from a separate read-only register. It also programs the transmit fill threshold below which the "transmit low" event fires.

A read returns its data one cycle after the request. The port controller has two named states. PORT_IDLE returns no data. PORT_RESP presents the captured word with `rd_valid` high. From either state, a read request moves it to PORT_RESP, and any other cycle moves it to PORT_IDLE. Writes take effect at the clock edge that samples them, in either state.

Top module: `spi_irq_unit`

## Requirements
- R1: While `rst_n` is low and after its release, event status and mask read 0, the threshold reads 1 and `irq` is 0.
- R2: Writing offset 0x08 sets each mask bit whose data bit is 1; bits written as 0 leave the mask unchanged.
- R3: Writing offset 0x0C clears each mask bit whose data bit is 1; bits written as 0 leave the mask unchanged.
- R4: The mask reads back at offset 0x10. Writes to 0x10 are ignored, and reads of the write-only offsets 0x08 and 0x0C return 0.
- R5: Event status reads at offset 0x04 (bits 6:0). Writing ones there clears those bits, and writing 0x7F clears every pending event whose condition has gone away.
- R6: The event bit positions are shared by status and mask. Bit 3 latches when `tx_full` is high. Bit 4 latches while `rx_count` is non-zero. Bits 0, 5 and 6 have no source and stay 0. Every latched bit stays set after its condition ends, until it is cleared.
- R7: If an event condition is present in the same cycle as a clear of its bit, the bit stays set.
- R8: `irq` is high exactly when some bit is set in both status and mask. A pending event whose mask bit is 0 does not raise `irq`.
- R9: Offset 0x28 holds the transmit threshold (read/write). Status bit 2 sets on every cycle in which `tx_count` is strictly below the threshold, and not when the two are equal.
- R10: A read request yields `rd_valid` high with the data on the next cycle. `rd_valid` is low one cycle after a cycle with no read request. Unmapped offsets read 0.
- R11: Status bit 1 latches only on a rising edge of `mode_fault`. A fault line held high does not set the bit again after it has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset of the register |
| req_wdata | input | DW | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | DW | Read data |
| tx_count | input | CNT_W | Transmit FIFO fill count |
| tx_full | input | 1 | Transmit FIFO full |
| rx_count | input | CNT_W | Receive FIFO fill count |
| mode_fault | input | 1 | Bus mode fault line |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that `mode_fault` stays low while reset is applied. Under that assumption, a fault seen in the first cycle after release counts as a genuine rising edge. They also assume that at most one register access arrives per cycle, which the port's single request line guarantees. The bench changes FIFO levels and the fault line only at falling clock edges and keeps them steady across each access. During the table walk it holds `tx_count` above the threshold, so that no unintended event reaches the status reads.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int IRQ_W       = 7;
    localparam int BIT_FAULT   = 1;
    localparam int BIT_TXLOW   = 2;
    localparam int BIT_TXFULL  = 3;
    localparam int BIT_RXAVAIL = 4;

    localparam logic [7:0] OFF_STATUS = 8'h04;
    localparam logic [7:0] OFF_SET    = 8'h08;
    localparam logic [7:0] OFF_CLR    = 8'h0C;
    localparam logic [7:0] OFF_MASK   = 8'h10;
    localparam logic [7:0] OFF_WMARK  = 8'h28;

    typedef enum logic {
        PORT_IDLE,
        PORT_RESP
    } port_state_t;

endpackage

// File: rtl/spi_irq_status.sv
module spi_irq_status
    import spi_irq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             tx_full,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             mode_fault,
    input  logic [CNT_W-1:0] wmark_q,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] clr_bits,
    output logic [IRQ_W-1:0] status_q
);

    logic             fault_q;
    logic [IRQ_W-1:0] raw_set;
    logic [IRQ_W-1:0] status_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= mode_fault;
    end

    always_comb begin
        raw_set              = '0;
        raw_set[BIT_FAULT]   = mode_fault & ~fault_q;
        raw_set[BIT_TXLOW]   = (tx_count < wmark_q);
        raw_set[BIT_TXFULL]  = tx_full;
        raw_set[BIT_RXAVAIL] = (rx_count != '0);
    end

    // new events win over a clear in the same cycle
    for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
        assign status_nxt[i] = raw_set[i] | (status_q[i] & ~(clr_we & clr_bits[i]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_nxt;
    end

endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask
    import spi_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] bits,
    output logic [IRQ_W-1:0] mask_q
);

    logic [IRQ_W-1:0] mask_nxt;

    for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
        assign mask_nxt[i] = (mask_q[i] | (set_we & bits[i])) & ~(clr_we & bits[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_nxt;
    end

endmodule

// File: rtl/spi_irq_regport.sv
module spi_irq_regport
    import spi_irq_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [IRQ_W-1:0] status_q,
    input  logic [IRQ_W-1:0] mask_q,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic             st_clr_we,
    output logic             mask_set_we,
    output logic             mask_clr_we,
    output logic [CNT_W-1:0] wmark_q
);

    port_state_t      state_q, state_nxt;
    logic             wr_req, rd_req;
    logic [DW-1:0]    rd_mux;
    logic             unused_wdata;

    assign wr_req       = req_valid & req_write;
    assign rd_req       = req_valid & ~req_write;
    assign unused_wdata = ^req_wdata;

    assign st_clr_we   = wr_req && (req_addr == AW'(OFF_STATUS));
    assign mask_set_we = wr_req && (req_addr == AW'(OFF_SET));
    assign mask_clr_we = wr_req && (req_addr == AW'(OFF_CLR));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PORT_IDLE;
        else        state_q <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = PORT_IDLE;
        unique case (state_q)
            PORT_IDLE: state_nxt = rd_req ? PORT_RESP : PORT_IDLE;
            PORT_RESP: state_nxt = rd_req ? PORT_RESP : PORT_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_valid = 1'b0;
        unique case (state_q)
            PORT_IDLE: rd_valid = 1'b0;
            PORT_RESP: rd_valid = 1'b1;
        endcase
    end

    always_comb begin
        rd_mux = '0;
        case (req_addr)
            AW'(OFF_STATUS): rd_mux[IRQ_W-1:0] = status_q;
            AW'(OFF_MASK):   rd_mux[IRQ_W-1:0] = mask_q;
            AW'(OFF_WMARK):  rd_mux[CNT_W-1:0] = wmark_q;
            default:         rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_req) rd_data <= rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wmark_q <= CNT_W'(1);
        else if (wr_req && (req_addr == AW'(OFF_WMARK)))
            wmark_q <= req_wdata[CNT_W-1:0];
    end

endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
    import spi_irq_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             tx_full,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             mode_fault,
    output logic             irq
);

    logic [IRQ_W-1:0] status_q;
    logic [IRQ_W-1:0] mask_q;
    logic [CNT_W-1:0] wmark_q;
    logic             st_clr_we, mask_set_we, mask_clr_we;

    spi_irq_regport #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .status_q    (status_q),
        .mask_q      (mask_q),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .st_clr_we   (st_clr_we),
        .mask_set_we (mask_set_we),
        .mask_clr_we (mask_clr_we),
        .wmark_q     (wmark_q)
    );

    spi_irq_status #(.CNT_W(CNT_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_count   (tx_count),
        .tx_full    (tx_full),
        .rx_count   (rx_count),
        .mode_fault (mode_fault),
        .wmark_q    (wmark_q),
        .clr_we     (st_clr_we),
        .clr_bits   (req_wdata[IRQ_W-1:0]),
        .status_q   (status_q)
    );

    spi_irq_mask u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (mask_set_we),
        .clr_we (mask_clr_we),
        .bits   (req_wdata[IRQ_W-1:0]),
        .mask_q (mask_q)
    );

    assign irq = |(status_q & mask_q);

endmodule

// File: rtl/spi_irq_unit_chk.sv
module spi_irq_unit_chk
    import spi_irq_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [AW-1:0]    req_addr,
    input logic [DW-1:0]    req_wdata,
    input logic             rd_valid,
    input logic [CNT_W-1:0] rx_count,
    input logic             mode_fault,
    input logic             irq,
    input logic [IRQ_W-1:0] status_q,
    input logic [IRQ_W-1:0] mask_q
);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_clear_chk: assert (status_q == '0 && mask_q == '0 && !irq);
        end
    end

    // R2
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == AW'(OFF_SET)) |=>
        ((mask_q & $past(req_wdata[IRQ_W-1:0])) == $past(req_wdata[IRQ_W-1:0])));

    // R3
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == AW'(OFF_CLR)) |=>
        ((mask_q & $past(req_wdata[IRQ_W-1:0])) == '0));

    // R6
    rx_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count != '0) |=> status_q[BIT_RXAVAIL]);

    // R8
    no_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    // R10
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    // R10
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);

    // R11
    fault_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_fault && $past(mode_fault) && $past(rst_n) && req_valid && req_write &&
         req_addr == AW'(OFF_STATUS) && req_wdata[BIT_FAULT]) |=> !status_q[BIT_FAULT]);

endmodule

bind spi_irq_unit spi_irq_unit_chk #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rd_valid   (rd_valid),
    .rx_count   (rx_count),
    .mode_fault (mode_fault),
    .irq        (irq),
    .status_q   (status_q),
    .mask_q     (mask_q)
);

// File: tb/spi_irq_unit_tb.sv
module spi_irq_unit_tb;

    localparam int AW = 8;
    localparam int DW = 32;
    localparam int CNT_W = 8;
    localparam int NV = 14;

    // {req[76:73], wr[72], addr[71:64], wdata[63:32], expect[31:0]}
    localparam logic [76:0] VEC [NV] = '{
        {4'd1,  1'b0, 8'h04, 32'h0,  32'h0},    // R1 status
        {4'd1,  1'b0, 8'h10, 32'h0,  32'h0},    // R1 mask
        {4'd1,  1'b0, 8'h28, 32'h0,  32'h1},    // R1 threshold
        {4'd2,  1'b1, 8'h08, 32'h16, 32'h0},    // R2 set bits 1,2,4
        {4'd2,  1'b0, 8'h10, 32'h0,  32'h16},
        {4'd2,  1'b1, 8'h08, 32'h00, 32'h0},    // R2 zero write
        {4'd2,  1'b0, 8'h10, 32'h0,  32'h16},
        {4'd3,  1'b1, 8'h0C, 32'h04, 32'h0},    // R3 clear bit 2
        {4'd3,  1'b0, 8'h10, 32'h0,  32'h12},
        {4'd4,  1'b0, 8'h08, 32'h0,  32'h0},    // R4 write-only reads 0
        {4'd9,  1'b1, 8'h28, 32'h03, 32'h0},    // R9 threshold 3
        {4'd9,  1'b0, 8'h28, 32'h0,  32'h3},
        {4'd4,  1'b1, 8'h10, 32'hFF, 32'h0},    // R4 mask write ignored
        {4'd4,  1'b0, 8'h10, 32'h0,  32'h12}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [AW-1:0]    req_addr = '0;
    logic [DW-1:0]    req_wdata = '0;
    logic             rd_valid;
    logic [DW-1:0]    rd_data;
    logic [CNT_W-1:0] tx_count = 8'd5;
    logic             tx_full = 1'b0;
    logic [CNT_W-1:0] rx_count = '0;
    logic             mode_fault = 1'b0;
    logic             irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] rd;

    spi_irq_unit #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .tx_count   (tx_count),
        .tx_full    (tx_full),
        .rx_count   (rx_count),
        .mode_fault (mode_fault),
        .irq        (irq)
    );

    always #10 clk = ~clk;

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 rd_valid after read", {31'b0, rd_valid}, 32'h1);
        d = rd_data;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        #1 rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 irq in reset", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) begin
                do_write(VEC[i][71:64], VEC[i][63:32]);
            end else begin
                do_read(VEC[i][71:64], rd);
                check($sformatf("R%0d vector %0d", VEC[i][76:73], i), rd, VEC[i][31:0]);
            end
        end

        // R6 / R8: receive data pending, bit 4 enabled
        rx_count = 8'd2;
        do_read(8'h04, rd);
        check("R6 rx pending status", rd, 32'h10);
        check("R8 irq on enabled event", {31'b0, irq}, 32'h1);

        // R7: clear while condition persists
        do_write(8'h04, 32'h10);
        do_read(8'h04, rd);
        check("R7 rx bit survives clear", rd, 32'h10);

        // R5: clear all once drained
        rx_count = '0;
        do_write(8'h04, 32'h7F);
        do_read(8'h04, rd);
        check("R5 clear all", rd, 32'h0);
        check("R5 irq low after clear", {31'b0, irq}, 32'h0);

        // R9 / R8: below threshold, bit 2 masked off
        tx_count = 8'd2;
        do_read(8'h04, rd);
        check("R9 tx below threshold", rd, 32'h04);
        check("R8 masked event no irq", {31'b0, irq}, 32'h0);
        tx_count = 8'd3;
        do_write(8'h04, 32'h04);
        do_read(8'h04, rd);
        check("R9 equal to threshold no event", rd, 32'h0);

        // R6: full pulse is sticky
        @(negedge clk); tx_full = 1'b1;
        @(negedge clk); tx_full = 1'b0;
        do_read(8'h04, rd);
        check("R6 tx full sticky", rd, 32'h08);
        do_write(8'h04, 32'h7F);
        do_read(8'h04, rd);
        check("R5 full cleared", rd, 32'h0);

        // R11: fault edge then held level
        @(negedge clk); mode_fault = 1'b1;
        do_read(8'h04, rd);
        check("R11 fault edge latched", rd, 32'h02);
        check("R8 fault irq", {31'b0, irq}, 32'h1);
        do_write(8'h04, 32'h02);
        do_read(8'h04, rd);
        check("R11 held fault no relatch", rd, 32'h0);
        check("R11 irq low", {31'b0, irq}, 32'h0);

        // R7: fault edge in the same cycle as its clear
        @(negedge clk); mode_fault = 1'b0;
        @(negedge clk);
        mode_fault = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h04; req_wdata = 32'h02;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        do_read(8'h04, rd);
        check("R7 fault edge beats clear", rd, 32'h02);
        mode_fault = 1'b0;
        do_write(8'h04, 32'h7F);

        // R10: unmapped offset, idle valid
        do_read(8'h3C, rd);
        check("R10 unmapped reads 0", rd, 32'h0);
        @(negedge clk);
        check("R10 rd_valid idle", {31'b0, rd_valid}, 32'h0);

        // R3: clear entire mask
        do_write(8'h0C, 32'h7F);
        do_read(8'h10, rd);
        check("R3 mask cleared", rd, 32'h0);

        // R1: reset mid-run
        do_write(8'h08, 32'h7F);
        do_write(8'h28, 32'h09);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 irq during reset", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        do_read(8'h10, rd);
        check("R1 mask after reset", rd, 32'h0);
        do_read(8'h28, rd);
        check("R1 threshold after reset", rd, 32'h1);
        do_read(8'h04, rd);
        check("R1 status after reset", rd, 32'h0);

        report();
    end

endmodule